// File: doc/BRIEF.md
# Decimating ADC conversion timer

This block produces the digital timing of a sigma-delta converter front end: when each conversion period ends, when a filtered result may be trusted, and whether a conversion run is still in progress. A 3-bit rate code picks one of eight uneven decimation ratios. One conversion period lasts the prescale count (448 clocks by default) times that ratio. Only the timing is modelled. The modulator, the filter arithmetic and the data path are outside the block.

A start pulse captures the rate code and the continuous/single selection. It clears both counters and resets the settle history. After that, the first valid result comes at the end of the fourth period. In continuous operation every later period also yields a valid result. In single operation the run ends after that fourth period. A step-event input marks a large input change while the filter was not reset. It pushes the next valid result out to the fifth period end after the event.

Top module: `adc_conv_timer`

## Requirements
- R1: After reset, `conv_tick`, `data_valid` and `busy` are all low, and no tick occurs until a start.
- R2: Rate codes 0 through 7 select decimation ratios 1096, 274, 220, 183, 55, 46, 27 and 23. While running, `conv_tick` pulses for exactly one clock every PRESCALE×ratio clocks. With the start captured at clock edge 0, the first pulse is visible after edge PRESCALE×ratio.
- R3: After a start, `data_valid` stays low through the first three period ends and first pulses together with the fourth `conv_tick`.
- R4: In continuous mode (`cont_en`=1 at start), every `conv_tick` after the fourth carries a `data_valid` pulse, and `data_valid` is never high without `conv_tick`.
- R5: In single mode (`cont_en`=0 at start), exactly four ticks occur. `data_valid` comes with the fourth tick, `busy` falls at that same edge, and no further tick follows.
- R6: `step_evt` high for one clock while busy suppresses `data_valid` until the fifth period end after the event. The tick rhythm is unchanged.
- R7: Changes of `rate_sel` or `cont_en` while running have no effect until the next start.
- R8: A start while running restarts the period count and the settle history from zero. It also drops any tick that would fall on that edge.
- R9: `data_valid` is never high on two consecutive clocks.
- R10: While `busy` has been low, `conv_tick` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 3 | Rate code selecting the decimation ratio |
| cont_en | input | 1 | 1 = continuous, 0 = single conversion (captured at start) |
| start | input | 1 | Start/restart pulse; resets counters and filter history |
| step_evt | input | 1 | Marks a large input step; reloads the settle count to five |
| conv_tick | output | 1 | One-clock pulse at each conversion period end |
| data_valid | output | 1 | One-clock pulse when a settled result is available |
| busy | output | 1 | High while a conversion run is active |

## Verification
The assertions assume `start` and `step_evt` are synchronous, single-clock pulses. They also assume PRESCALE×ratio is at least two clocks, so ticks cannot land on adjacent edges. The directed stimulus drives every input on the falling edge and keeps each pulse one clock long. It places step events in the middle of a period, so a reload never coincides with a period end. It uses a prescale of four, so that all eight ratios and several settle sequences fit into a short run.

// File: rtl/adc_tmr_pkg.sv
package adc_tmr_pkg;

  localparam int RATIO_W = 11;
  localparam int CODE_W  = 3;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd0:    r = 11'd1096;
      3'd1:    r = 11'd274;
      3'd2:    r = 11'd220;
      3'd3:    r = 11'd183;
      3'd4:    r = 11'd55;
      3'd5:    r = 11'd46;
      3'd6:    r = 11'd27;
      default: r = 11'd23;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int PRESCALE = 448
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic wrap
);
  localparam int CNT_W = $clog2(PRESCALE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (en)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign wrap = en && (cnt_q == LAST);

  p_pre_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/adc_decimator.sv
module adc_decimator
  import adc_tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               load,
  input  logic [CODE_W-1:0]  code_in,
  input  logic               adv,
  output logic               period_end
);
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] cnt_q;
  logic               last;

  always_ff @(posedge clk) begin
    if (rst)       ratio_q <= ratio_of(CODE_W'(7));
    else if (load) ratio_q <= ratio_of(code_in);
  end

  assign last = (cnt_q == ratio_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (adv)   cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  assign period_end = adv && last;

  p_decim_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < ratio_q);
  p_ratio_held_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ratio_q));
endmodule

// File: rtl/adc_settle_track.sv
module adc_settle_track #(
  parameter int FIRST_PERIODS = 4,
  parameter int STEP_PERIODS  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic step_hit,
  input  logic period_end,
  output logic valid_now
);
  localparam int S_W = $clog2(STEP_PERIODS + 1);
  localparam logic [S_W-1:0] S_FIRST = S_W'(FIRST_PERIODS);
  localparam logic [S_W-1:0] S_STEP  = S_W'(STEP_PERIODS);

  logic [S_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)             left_q <= S_FIRST;
    else if (restart)    left_q <= S_FIRST;
    else if (step_hit)   left_q <= S_STEP;
    else if (period_end) left_q <= (left_q > 1) ? left_q - 1'b1 : '0;
  end

  assign valid_now = period_end && !restart && !step_hit && (left_q <= 1);

  p_restart_settle_r3: assert property (@(posedge clk) disable iff (rst)
    restart |=> (left_q == S_FIRST));
  p_step_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (step_hit && !restart) |=> (left_q == S_STEP));
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_tmr_pkg::*;
#(
  parameter int PRESCALE      = 448,
  parameter int FIRST_PERIODS = 4,
  parameter int STEP_PERIODS  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] rate_sel,
  input  logic              cont_en,
  input  logic              start,
  input  logic              step_evt,
  output logic              conv_tick,
  output logic              data_valid,
  output logic              busy
);
  logic busy_q, cont_q, tick_q, valid_q;
  logic pre_wrap, period_end, valid_now;

  adc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .clr(start), .en(busy_q), .wrap(pre_wrap)
  );

  adc_decimator u_dec (
    .clk(clk), .rst(rst), .clr(start), .load(start), .code_in(rate_sel),
    .adv(pre_wrap), .period_end(period_end)
  );

  adc_settle_track #(.FIRST_PERIODS(FIRST_PERIODS), .STEP_PERIODS(STEP_PERIODS)) u_set (
    .clk(clk), .rst(rst), .restart(start), .step_hit(step_evt && busy_q),
    .period_end(period_end), .valid_now(valid_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cont_q  <= 1'b0;
      tick_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      tick_q  <= period_end && !start;
      valid_q <= valid_now;
      if (start) begin
        busy_q <= 1'b1;
        cont_q <= cont_en;
      end else if (valid_now && !cont_q) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign conv_tick  = tick_q;
  assign data_valid = valid_q;
  assign busy       = busy_q;

  p_valid_has_tick_r4: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> conv_tick);
  p_valid_one_wide_r9: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid);
  p_tick_one_wide_r2: assert property (@(posedge clk) disable iff (rst)
    conv_tick |=> !conv_tick);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !conv_tick);
  p_single_stops_r5: assert property (@(posedge clk) disable iff (rst)
    (data_valid && !busy) |=> !busy || $past(start));
endmodule

// File: tb/adc_conv_timer_tb_top.sv
`timescale 1ns/1ps
module adc_conv_timer_tb_top;
  localparam int PRE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] rate_sel = 3'd7;
  logic cont_en = 1'b0, start = 1'b0, step_evt = 1'b0;
  logic conv_tick, data_valid, busy;

  int n_checks = 0, n_errs = 0;
  int k = 0;          // edges since the captured start
  int per = 1;        // expected period in clocks
  int fv = 4;         // period index of first expected valid
  bit mode_cont = 1'b0;
  bit running = 1'b0;

  always #2 clk = ~clk;

  adc_conv_timer #(.PRESCALE(PRE)) dut_i (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .cont_en(cont_en),
    .start(start), .step_evt(step_evt),
    .conv_tick(conv_tick), .data_valid(data_valid), .busy(busy)
  );

  function automatic int bench_ratio(input int c);
    int t[8] = '{1096, 274, 220, 183, 55, 46, 27, 23};
    return t[c];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input int code, input bit cont);
    @(negedge clk);
    rate_sel = 3'(code); cont_en = cont; start = 1'b1;
    @(posedge clk);
    k = 0; per = PRE * bench_ratio(code); fv = 4; mode_cont = cont; running = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Runs n cycles comparing all outputs against the expected pattern.
  task automatic run_span(input int n, input string req);
    int bad_t = 0, bad_v = 0, bad_b = 0;
    int at = 0, av = 0, ab = 0, et = 0, ev = 0, eb = 0;
    for (int i = 0; i < n; i++) begin
      bit e_t, e_v, e_b;
      @(posedge clk);
      k++;
      @(negedge clk);
      e_b = running && (mode_cont || k < 4 * per);
      e_t = running && (k % per == 0) && (mode_cont || k <= 4 * per);
      e_v = e_t && (k / per >= fv) && (mode_cont || k == 4 * per);
      if (conv_tick !== e_t && bad_t == 0) begin at = conv_tick; et = e_t; end
      if (data_valid !== e_v && bad_v == 0) begin av = data_valid; ev = e_v; end
      if (busy !== e_b && bad_b == 0) begin ab = busy; eb = e_b; end
      if (conv_tick !== e_t) bad_t++;
      if (data_valid !== e_v) bad_v++;
      if (busy !== e_b) bad_b++;
    end
    check(bad_t == 0, {req, " conv_tick"}, at, et);
    check(bad_v == 0, {req, " data_valid"}, av, ev);
    check(bad_b == 0, {req, " busy"}, ab, eb);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(conv_tick == 1'b0 && data_valid == 1'b0 && busy == 1'b0, "R1 reset outputs",
          {conv_tick, data_valid, busy}, 0);
    run_span(200, "R1 idle after reset");
  endtask

  task automatic t_rate_sweep;
    for (int c = 0; c < 8; c++) begin
      do_start(c, 1'b1);
      run_span(2 * PRE * bench_ratio(c) + 1, $sformatf("R2 code %0d", c));
    end
  endtask

  task automatic t_continuous;
    do_start(7, 1'b1);
    run_span(7 * per, "R3 R4 continuous settle");
  endtask

  task automatic t_single;
    do_start(6, 1'b0);
    run_span(6 * per, "R5 R10 single conversion");
    running = 1'b0;
  endtask

  task automatic t_step;
    do_start(7, 1'b1);
    run_span(5 * per + per / 2, "R6 before step");
    step_evt = 1'b1;
    fv = k / per + 5;
    run_span(1, "R6 step cycle");
    step_evt = 1'b0;
    run_span(7 * per, "R6 after step");
  endtask

  task automatic t_rate_change;
    do_start(7, 1'b1);
    run_span(per + 3, "R7 before change");
    rate_sel = 3'd0; cont_en = 1'b0;
    run_span(6 * per, "R7 after change");
  endtask

  task automatic t_restart;
    do_start(7, 1'b1);
    run_span(5 * per + 7, "R8 before restart");
    do_start(6, 1'b1);
    run_span(6 * per, "R8 after restart");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_rate_sweep();
    t_continuous();
    t_single();
    t_step();
    t_rate_change();
    t_restart();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule